// File: doc/BRIEF.md
# Cascadable Serial Register Loader

This block is the serial programming port of a frequency synthesizer. While the active-low select `sel_n` is held low, it samples `sdi` on each rising edge of `sclk`, most significant bit first. No address field is used. When select is released, the number of bits received picks the target register: 8 bits write the configuration register, 16 bits write the reference-ratio register and 24 bits write the divide register. The serial inputs are assumed to be synchronous to the block clock `clk`, which samples them.

The reference-ratio register is double buffered. A 16-bit write only fills a pending copy. The next divide-register write moves that pending copy to `ref_q` in the same cycle as `div_q` changes, and `ratio_stb` marks the moment. Devices can be chained: the configurable pin `out_a` can carry the bit that falls off the top of the 24-bit chain. A transfer longer than 24 bits whose length is a multiple of 8 therefore loads the divide register with its last 24 bits, while the earlier bits pass on to the next device. The configuration register also drives phase-detector select, standby and the static level of `out_b`. The counters and detectors themselves lie outside this block.

The controller has four states. ST_IDLE holds the chain and the bit counter cleared. The transition sel_fall moves it to ST_SHIFT, where edges are taken. The transition sel_rise_ok goes to ST_COMMIT when the length is valid, and sel_rise_bad goes to ST_DROP when it is not. The transition retire returns from either of those two states to ST_IDLE.

Top module: `serial_reg_loader`

## Requirements
- R1: After reset `cfg_q`, `ref_q`, `div_q`, `out_a`, `out_b`, `pd_sel_a` and `standby` are 0, and neither strobe has pulsed.
- R2: Bits are taken only on a rising `sclk` while `sel_n` is low and the controller is shifting. A rising `sclk` in the same cycle that `sel_n` goes high is not counted.
- R3: An 8-bit transfer writes `cfg_q` with the received byte (first bit into bit 7) and pulses `cfg_stb` for one cycle.
- R4: A 16-bit transfer changes neither `ref_q` nor `div_q` and gives no `ratio_stb`. It only fills the pending reference value.
- R5: A 24-bit transfer writes `div_q` and, in the same cycle, copies the pending reference value to `ref_q`, with one `ratio_stb` pulse.
- R6: A transfer of 0 bits, or of any length that is not a multiple of 8, changes no register and pulses no strobe.
- R7: A transfer whose length is a multiple of 8 above 24 loads `div_q` with the last 24 bits received.
- R8: At each accepted edge, the serial data out takes the bit at the top of the 24-bit chain before the shift. After edge k, it shows the bit received at edge k-24, or 0 if k is 24 or less.
- R9: `cfg_q[3:2]` selects `out_a`: 00 drives 0, 01 drives 1, 10 drives serial data out, and 11 drives 1 while shifting and 0 otherwise.
- R10: `cfg_q[0]` drives `standby` (1 is standby), `cfg_q[1]` drives `pd_sel_a` (1 selects detector A, 0 detector B) and `cfg_q[4]` drives `out_b`.
- R11: While idle, the chain, the bit counter and serial data out are cleared, so an aborted transfer does not affect the length or the data of the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, rising edge samples data |
| sdi | input | 1 | Serial data in |
| sel_n | input | 1 | Active-low transfer select |
| out_a | output | 1 | General output, mode set by configuration |
| out_b | output | 1 | Static general output from configuration |
| pd_sel_a | output | 1 | 1 selects phase detector A, 0 selects B |
| standby | output | 1 | Standby request |
| cfg_q | output | 8 | Configuration register |
| ref_q | output | 16 | Active reference ratio |
| div_q | output | 24 | Divide register |
| cfg_stb | output | 1 | One-cycle pulse on configuration write |
| ratio_stb | output | 1 | One-cycle pulse when `div_q` and `ref_q` update together |

## Verification
Two events can land in the same `clk` cycle: the release of `sel_n`, which ends a transfer, and a rising `sclk`, which would add one more bit. The bench provokes this by sending an 8-bit transfer and then raising `sclk` together with `sel_n`. The extra edge must be ignored, so the byte must land in `cfg_q` unshifted and `cfg_stb` must pulse once. A second coincidence is the double-buffer copy: a divide write must move the pending reference value in the same cycle. The bench judges this by `ref_q` and `div_q` both changing under one `ratio_stb` pulse.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2,
        ST_DROP   = 2'd3
    } ldr_state_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_CFG  = 2'd1,
        TGT_REF  = 2'd2,
        TGT_DIV  = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        OA_LOW  = 2'b00,
        OA_HIGH = 2'b01,
        OA_SDO  = 2'b10,
        OA_BUSY = 2'b11
    } outa_mode_e;
endpackage

// File: rtl/sreg_shift.sv
module sreg_shift #(
    parameter int CHAIN_W = 24,
    parameter int CNT_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               sdi,
    input  logic               shift_en,
    input  logic               clear,
    output logic [CHAIN_W-1:0] chain,
    output logic [CNT_W-1:0]   bit_cnt,
    output logic               sdo
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic sclk_q;
    logic take;

    assign take = shift_en && sclk && !sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain   <= '0;
            bit_cnt <= '0;
            sdo     <= 1'b0;
        end else if (clear) begin
            chain   <= '0;
            bit_cnt <= '0;
            sdo     <= 1'b0;
        end else if (take) begin
            sdo   <= chain[CHAIN_W-1];
            chain <= {chain[CHAIN_W-2:0], sdi};
            if (bit_cnt != CNT_MAX) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // R11: idle clears length, chain and data out
    assert_idle_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (bit_cnt == '0) && (chain == '0) && !sdo);

    // R2: nothing moves without an enabled edge
    assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !clear) |=> $stable(chain) && $stable(bit_cnt));
endmodule

// File: rtl/sreg_fsm.sv
module sreg_fsm #(
    parameter int CNT_W = 7,
    parameter int CFG_W = 8,
    parameter int REF_W = 16,
    parameter int DIV_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic [CNT_W-1:0] bit_cnt,
    output logic             shift_en,
    output logic             clear,
    output logic             busy,
    output logic             ld_cfg,
    output logic             ld_ref,
    output logic             ld_div
);
    import sreg_pkg::*;

    localparam logic [CNT_W-1:0] LEN_CFG = CNT_W'(CFG_W);
    localparam logic [CNT_W-1:0] LEN_REF = CNT_W'(REF_W);
    localparam logic [CNT_W-1:0] LEN_DIV = CNT_W'(DIV_W);

    ldr_state_e state, nxt;
    tgt_e       tgt;

    always_comb begin
        tgt = TGT_NONE;
        if (bit_cnt == LEN_CFG) begin
            tgt = TGT_CFG;
        end else if (bit_cnt == LEN_REF) begin
            tgt = TGT_REF;
        end else if (bit_cnt >= LEN_DIV && bit_cnt[2:0] == 3'b000) begin
            tgt = TGT_DIV;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (!sel_n) nxt = ST_SHIFT;
            ST_SHIFT:  if (sel_n) nxt = (tgt != TGT_NONE) ? ST_COMMIT : ST_DROP;
            ST_COMMIT: nxt = ST_IDLE;
            ST_DROP:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        shift_en = (state == ST_SHIFT) && !sel_n;
        clear    = (state == ST_IDLE);
        busy     = (state == ST_SHIFT);
        ld_cfg   = (state == ST_COMMIT) && (tgt == TGT_CFG);
        ld_ref   = (state == ST_COMMIT) && (tgt == TGT_REF);
        ld_div   = (state == ST_COMMIT) && (tgt == TGT_DIV);
    end

    // R6: a bad length ends without any load
    assert_bad_len_no_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && sel_n && tgt == TGT_NONE) |=> !(ld_cfg || ld_ref || ld_div));

    // R3: at most one register targeted
    assert_single_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_cfg, ld_ref, ld_div}));

    // R2: no edge accepted once select is high
    assert_sel_gates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> !shift_en);
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank #(
    parameter int CFG_W = 8,
    parameter int REF_W = 16,
    parameter int DIV_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] chain,
    input  logic             ld_cfg,
    input  logic             ld_ref,
    input  logic             ld_div,
    output logic [CFG_W-1:0] cfg_q,
    output logic [REF_W-1:0] ref_q,
    output logic [DIV_W-1:0] div_q,
    output logic             cfg_stb,
    output logic             ratio_stb
);
    logic [REF_W-1:0] ref_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            ref_pend  <= '0;
            ref_q     <= '0;
            div_q     <= '0;
            cfg_stb   <= 1'b0;
            ratio_stb <= 1'b0;
        end else begin
            cfg_stb   <= ld_cfg;
            ratio_stb <= ld_div;
            if (ld_cfg) cfg_q <= chain[CFG_W-1:0];
            if (ld_ref) ref_pend <= chain[REF_W-1:0];
            if (ld_div) begin
                div_q <= chain;
                ref_q <= ref_pend;
            end
        end
    end

    // R4: a reference write leaves the active ratio alone
    assert_ref_buffered_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ref |=> $stable(ref_q) && $stable(div_q) && !ratio_stb);

    // R5: divide load carries the pending reference with it
    assert_ratio_together_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_div |=> ratio_stb && (ref_q == $past(ref_pend)) && (div_q == $past(chain)));
endmodule

// File: rtl/serial_reg_loader.sv
module serial_reg_loader #(
    parameter int CFG_W = 8,
    parameter int REF_W = 16,
    parameter int DIV_W = 24,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             sdi,
    input  logic             sel_n,
    output logic             out_a,
    output logic             out_b,
    output logic             pd_sel_a,
    output logic             standby,
    output logic [CFG_W-1:0] cfg_q,
    output logic [REF_W-1:0] ref_q,
    output logic [DIV_W-1:0] div_q,
    output logic             cfg_stb,
    output logic             ratio_stb
);
    import sreg_pkg::*;

    logic [DIV_W-1:0] chain;
    logic [CNT_W-1:0] bit_cnt;
    logic             sdo, shift_en, clear, busy;
    logic             ld_cfg, ld_ref, ld_div;
    outa_mode_e       mode;

    sreg_shift #(.CHAIN_W(DIV_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi),
        .shift_en(shift_en), .clear(clear),
        .chain(chain), .bit_cnt(bit_cnt), .sdo(sdo)
    );

    sreg_fsm #(.CNT_W(CNT_W), .CFG_W(CFG_W), .REF_W(REF_W), .DIV_W(DIV_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .bit_cnt(bit_cnt),
        .shift_en(shift_en), .clear(clear), .busy(busy),
        .ld_cfg(ld_cfg), .ld_ref(ld_ref), .ld_div(ld_div)
    );

    sreg_bank #(.CFG_W(CFG_W), .REF_W(REF_W), .DIV_W(DIV_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .chain(chain),
        .ld_cfg(ld_cfg), .ld_ref(ld_ref), .ld_div(ld_div),
        .cfg_q(cfg_q), .ref_q(ref_q), .div_q(div_q),
        .cfg_stb(cfg_stb), .ratio_stb(ratio_stb)
    );

    assign mode     = outa_mode_e'(cfg_q[3:2]);
    assign standby  = cfg_q[0];
    assign pd_sel_a = cfg_q[1];
    assign out_b    = cfg_q[4];

    always_comb begin
        unique case (mode)
            OA_LOW:  out_a = 1'b0;
            OA_HIGH: out_a = 1'b1;
            OA_SDO:  out_a = sdo;
            OA_BUSY: out_a = busy;
            default: out_a = 1'b0;
        endcase
    end

    // R9: data-out mode is silent while idle
    assert_sdo_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OA_SDO && clear && $past(clear)) |-> !out_a);
endmodule

// File: tb/tb_serial_reg_loader.sv
module tb_serial_reg_loader;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        sel_n = 1'b1;
    logic        out_a, out_b, pd_sel_a, standby, cfg_stb, ratio_stb;
    logic [7:0]  cfg_q;
    logic [15:0] ref_q;
    logic [23:0] div_q;

    int checks = 0;
    int fails = 0;
    int n_cfg_stb = 0;
    int n_ratio_stb = 0;
    logic [63:0] obs;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_reg_loader dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .sel_n(sel_n),
        .out_a(out_a), .out_b(out_b), .pd_sel_a(pd_sel_a), .standby(standby),
        .cfg_q(cfg_q), .ref_q(ref_q), .div_q(div_q),
        .cfg_stb(cfg_stb), .ratio_stb(ratio_stb)
    );

    always @(posedge clk) begin
        if (cfg_stb) n_cfg_stb <= n_cfg_stb + 1;
        if (ratio_stb) n_ratio_stb <= n_ratio_stb + 1;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Send n bits of data, first bit = data[n-1]; optional extra edge with select release
    task automatic xfer(input logic [63:0] data, input int n, input bit late_edge);
        obs = '0;
        sel_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            sdi  = data[n-1-i];
            sclk = 1'b0;
            repeat (2) @(negedge clk);
            sclk = 1'b1;
            @(negedge clk);
            obs[i] = out_a;
            @(negedge clk);
        end
        sclk = 1'b0;
        repeat (2) @(negedge clk);
        if (late_edge) begin
            sdi  = 1'b1;
            sclk = 1'b1;
        end
        sel_n = 1'b1;
        repeat (5) @(negedge clk);
        sclk = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 cfg", cfg_q, 0);
        check("R1 ref", ref_q, 0);
        check("R1 div", div_q, 0);
        check("R1 pins", {out_a, out_b, pd_sel_a, standby}, 0);
        check("R1 strobes", n_cfg_stb + n_ratio_stb, 0);
    endtask

    task automatic t_config;
        int c0 = n_cfg_stb;
        xfer(64'h17, 8, 1'b0);
        check("R3 cfg value", cfg_q, 8'h17);
        check("R3 one strobe", n_cfg_stb - c0, 1);
        check("R10 standby/pd/out_b", {standby, pd_sel_a, out_b}, 3'b111);
        check("R9 mode high", out_a, 1);
        xfer(64'h00, 8, 1'b0);
        check("R9 mode low", out_a, 0);
        check("R10 cleared", {standby, pd_sel_a, out_b}, 3'b000);
    endtask

    task automatic t_double_buffer;
        int r0 = n_ratio_stb;
        xfer(64'h1234, 16, 1'b0);
        check("R4 ref unchanged", ref_q, 0);
        check("R4 div unchanged", div_q, 0);
        check("R4 no ratio strobe", n_ratio_stb - r0, 0);
        xfer(64'hABCDEF, 24, 1'b0);
        check("R5 div", div_q, 24'hABCDEF);
        check("R5 ref moved", ref_q, 16'h1234);
        check("R5 one strobe", n_ratio_stb - r0, 1);
    endtask

    task automatic t_bad_length;
        int c0 = n_cfg_stb;
        int r0 = n_ratio_stb;
        xfer(64'h1F, 5, 1'b0);
        xfer(64'hFFF, 12, 1'b0);
        xfer(64'h0, 0, 1'b0);
        check("R6 cfg kept", cfg_q, 8'h00);
        check("R6 ref kept", ref_q, 16'h1234);
        check("R6 div kept", div_q, 24'hABCDEF);
        check("R6 no strobes", (n_cfg_stb - c0) + (n_ratio_stb - r0), 0);
        // R11: aborted 5 bits leave no trace on the next 16-bit write
        xfer(64'h1F, 5, 1'b0);
        xfer(64'h0F0F, 16, 1'b0);
        xfer(64'h000001, 24, 1'b0);
        check("R11 ref fresh", ref_q, 16'h0F0F);
    endtask

    task automatic t_late_edge;
        int c0 = n_cfg_stb;
        xfer(64'h12, 8, 1'b1);
        check("R2 edge at release ignored", cfg_q, 8'h12);
        check("R2 single strobe", n_cfg_stb - c0, 1);
    endtask

    task automatic t_cascade;
        logic [31:0] stream = 32'h5AC396F1;
        logic ok = 1'b1;
        xfer(64'h08, 8, 1'b0);
        check("R9 sdo idle low", out_a, 0);
        xfer({32'h0, stream}, 32, 1'b0);
        for (int k = 1; k <= 32; k++) begin
            logic e;
            e = (k > 24) ? stream[32 - (k - 24)] : 1'b0;
            if (obs[k-1] !== e) ok = 1'b0;
        end
        check("R8 data out delayed 24", ok, 1);
        check("R7 long load tail", div_q, 24'hC396F1);
        check("R9 sdo low after", out_a, 0);
        xfer(64'h0C, 8, 1'b0);
        xfer(64'h0C, 8, 1'b0);
        check("R9 busy during shift", obs[7:0], 8'hFF);
        check("R9 busy low idle", out_a, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_config();
        t_double_buffer();
        t_bad_length();
        t_late_edge();
        t_cascade();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule